// File: doc/BRIEF.md
# RGB Panel Sync Timing Generator

This block produces the horizontal sync, vertical sync and data-enable strobes for a parallel RGB display panel. It also exposes the current pixel column and line counters. A free-running system clock drives it, and a pixel-clock enable gates each step of the counters. A one-cycle start strobe clears both counters and begins scanning. When the last pixel of a frame has been consumed, the generator does one of two things: with the repeat control set it begins the next frame at once, and with it clear it falls back to idle.

The line and frame geometry is programmed in a cumulative minus-one form. For each axis there are four values: sync width − 1, (sync + back porch) − 1, active size − 1, and total − 1, where the total is sync + back porch + active + front porch. Further settings control:
- the column at which the horizontal sync pulse starts;
- whether horizontal sync pulses appear on lines outside the active window;
- the idle level of each of the three strobes;
- an extra delay, in clock cycles, for each strobe separately.

A frame-end pulse sets a sticky status bit. That bit can be cleared and masked before it reaches the interrupt output.

Top module: `rgb_sync_gen`

## Requirements
- R1: While reset is asserted and after it is released, each of hsync_o, vsync_o and de_o sits at its idle input level, and pix_req_o, frame_end_o, irq_o, irq_status_o, h_cnt_o and v_cnt_o are all 0.
- R2: A start_i pulse sets h_cnt_o and v_cnt_o to 0 at the next clock edge and enables scanning. On each later edge with pix_en_i high, h_cnt_o increments. At h_cnt_o == h_total_i it returns to 0, and v_cnt_o then increments, or returns to 0 at v_total_i. On edges with pix_en_i low, both counters hold.
- R3: Before the output stage, HSYNC is active when hs_pos_i ≤ h_cnt ≤ hs_pos_i + h_sync_w_i. The pulse is cut off at the end of the line and does not carry over into the next line.
- R4: On lines outside the active vertical window, HSYNC is produced only when hs_porch_en_i is 1. When it is 0, hsync_o stays at its idle level on those lines.
- R5: Before the output stage, VSYNC is active on lines where v_cnt ≤ v_sync_w_i.
- R6: DE is active where h_back_i+1 ≤ h_cnt ≤ h_back_i+1+h_act_i and v_back_i+1 ≤ v_cnt ≤ v_back_i+1+v_act_i. pix_req_o shows this same window one clock after the counters, with no added delay and active high.
- R7: Each strobe output equals its idle input XOR its active state. A 1 on hs_idle_i, vs_idle_i or de_idle_i therefore makes that strobe active-low. When the generator is not scanning, every strobe is at idle.
- R8: hsync_o, vsync_o and de_o follow the counters after 1 + N clock cycles, where N is hs_dly_i, vs_dly_i or de_dly_i respectively (range 0 to 3).
- R9: If auto_next_i is 1 when the last pixel of a frame is consumed, scanning continues from column 0 of line 0. If it is 0, scanning stops with both counters at 0 and stays stopped until the next start_i.
- R10: frame_end_o is high for exactly the one clock cycle that follows the edge at which the last pixel of a frame (h_total_i, v_total_i) is consumed.
- R11: irq_status_o is set by each frame end and cleared by irq_clr_i. When both occur in the same cycle, setting wins. irq_o = irq_status_o AND irq_en_i.
- R12: A start_i pulse during a frame restarts the frame from counters 0 at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_en_i | input | 1 | Pixel step enable |
| start_i | input | 1 | Start / restart strobe |
| auto_next_i | input | 1 | 1: repeat frames, 0: single frame |
| h_sync_w_i | input | HW | Horizontal sync width − 1 |
| h_back_i | input | HW | Horizontal sync + back porch − 1 |
| h_act_i | input | HW | Active width − 1 |
| h_total_i | input | HW | Line total − 1 |
| v_sync_w_i | input | VW | Vertical sync width − 1 (lines) |
| v_back_i | input | VW | Vertical sync + back porch − 1 |
| v_act_i | input | VW | Active height − 1 |
| v_total_i | input | VW | Frame total − 1 |
| hs_pos_i | input | HW | Column where HSYNC begins |
| hs_porch_en_i | input | 1 | HSYNC on non-active lines |
| hs_idle_i | input | 1 | HSYNC idle level |
| vs_idle_i | input | 1 | VSYNC idle level |
| de_idle_i | input | 1 | DE idle level |
| hs_dly_i | input | DW | HSYNC extra delay |
| vs_dly_i | input | DW | VSYNC extra delay |
| de_dly_i | input | DW | DE extra delay |
| irq_en_i | input | 1 | Interrupt enable |
| irq_clr_i | input | 1 | Status clear |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Data enable |
| pix_req_o | output | 1 | Active-pixel request |
| frame_end_o | output | 1 | Frame-end pulse |
| irq_status_o | output | 1 | Sticky frame-end status |
| irq_o | output | 1 | Masked interrupt |
| h_cnt_o | output | HW | Column counter |
| v_cnt_o | output | VW | Line counter |

## Verification
The embedded assertions check several rules on every cycle:
- the counters hold when neither a step nor a start occurs;
- single-frame mode stops after the last pixel;
- every frame-end pulse is accompanied by the status bit;
- a clear with no coincident frame end empties that bit.

Other behaviour can only be shown by the bench scenarios, where a cycle model follows the design through several configurations:
- the shape and position of the sync and data-enable windows;
- truncation of the sync pulse at the end of the line;
- HSYNC suppression on porch lines;
- polarity inversion and the per-strobe delays;
- restart during a frame and irregular pixel-enable patterns.

// File: rtl/rgb_sync_pkg.sv
package rgb_sync_pkg;
  typedef struct packed {
    logic de;
    logic vs;
    logic hs;
  } sync_t;

  localparam int unsigned NSIG = 3;
endpackage

// File: rtl/rgb_sync_counter.sv
module rgb_sync_counter #(
  parameter int unsigned HW = 12,
  parameter int unsigned VW = 11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pix_en_i,
  input  logic          start_i,
  input  logic          auto_next_i,
  input  logic [HW-1:0] h_total_i,
  input  logic [VW-1:0] v_total_i,
  output logic [HW-1:0] h_cnt_o,
  output logic [VW-1:0] v_cnt_o,
  output logic          run_o,
  output logic          frame_evt_o
);
  localparam logic [HW-1:0] H_ONE = 1;
  localparam logic [VW-1:0] V_ONE = 1;

  logic [HW-1:0] h_q;
  logic [VW-1:0] v_q;
  logic          run_q;
  logic          step, h_last, v_last;

  assign step        = run_q & pix_en_i;
  assign h_last      = (h_q == h_total_i);
  assign v_last      = (v_q == v_total_i);
  assign frame_evt_o = step & h_last & v_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_q   <= '0;
      v_q   <= '0;
      run_q <= 1'b0;
    end else if (start_i) begin
      h_q   <= '0;
      v_q   <= '0;
      run_q <= 1'b1;
    end else if (step) begin
      if (h_last) begin
        h_q <= '0;
        if (v_last) begin
          v_q <= '0;
          if (!auto_next_i) run_q <= 1'b0;
        end else begin
          v_q <= v_q + V_ONE;
        end
      end else begin
        h_q <= h_q + H_ONE;
      end
    end
  end

  assign h_cnt_o = h_q;
  assign v_cnt_o = v_q;
  assign run_o   = run_q;

  // R2
  hold_when_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && !pix_en_i) |=> ($stable(h_q) && $stable(v_q)));

  // R9
  single_frame_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_evt_o && !auto_next_i && !start_i) |=> (!run_q && h_q == '0 && v_q == '0));
endmodule

// File: rtl/rgb_sync_decode.sv
module rgb_sync_decode
  import rgb_sync_pkg::*;
#(
  parameter int unsigned HW = 12,
  parameter int unsigned VW = 11
) (
  input  logic          run_i,
  input  logic [HW-1:0] h_cnt_i,
  input  logic [VW-1:0] v_cnt_i,
  input  logic [HW-1:0] h_sync_w_i,
  input  logic [HW-1:0] h_back_i,
  input  logic [HW-1:0] h_act_i,
  input  logic [VW-1:0] v_sync_w_i,
  input  logic [VW-1:0] v_back_i,
  input  logic [VW-1:0] v_act_i,
  input  logic [HW-1:0] hs_pos_i,
  input  logic          hs_porch_en_i,
  output sync_t         raw_o
);
  localparam logic [HW:0] H_ONE = 1;
  localparam logic [VW:0] V_ONE = 1;

  logic [HW:0] hc, hs_lo, hs_hi, de_lo, de_hi;
  logic [VW:0] vc, dv_lo, dv_hi;
  logic        hs_win, de_col, act_line;

  always_comb begin
    hc       = {1'b0, h_cnt_i};
    vc       = {1'b0, v_cnt_i};
    hs_lo    = {1'b0, hs_pos_i};
    hs_hi    = hs_lo + {1'b0, h_sync_w_i};
    de_lo    = {1'b0, h_back_i} + H_ONE;
    de_hi    = de_lo + {1'b0, h_act_i};
    dv_lo    = {1'b0, v_back_i} + V_ONE;
    dv_hi    = dv_lo + {1'b0, v_act_i};
    hs_win   = (hc >= hs_lo) && (hc <= hs_hi);
    de_col   = (hc >= de_lo) && (hc <= de_hi);
    act_line = (vc >= dv_lo) && (vc <= dv_hi);
    raw_o.hs = run_i & hs_win & (act_line | hs_porch_en_i);
    raw_o.vs = run_i & (v_cnt_i <= v_sync_w_i);
    raw_o.de = run_i & de_col & act_line;
  end
endmodule

// File: rtl/rgb_sync_delay.sv
module rgb_sync_delay #(
  parameter int unsigned DW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          d_i,
  input  logic [DW-1:0] dly_i,
  output logic          q_o
);
  localparam int unsigned MAXD = (1 << DW) - 1;

  logic [MAXD:0] tap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tap_q[0] <= 1'b0;
    else         tap_q[0] <= d_i;
  end

  for (genvar k = 1; k <= MAXD; k++) begin : g_tap
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) tap_q[k] <= 1'b0;
      else         tap_q[k] <= tap_q[k-1];
    end
  end

  assign q_o = tap_q[dly_i];
endmodule

// File: rtl/rgb_sync_gen.sv
module rgb_sync_gen
  import rgb_sync_pkg::*;
#(
  parameter int unsigned HW = 12,
  parameter int unsigned VW = 11,
  parameter int unsigned DW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pix_en_i,
  input  logic          start_i,
  input  logic          auto_next_i,
  input  logic [HW-1:0] h_sync_w_i,
  input  logic [HW-1:0] h_back_i,
  input  logic [HW-1:0] h_act_i,
  input  logic [HW-1:0] h_total_i,
  input  logic [VW-1:0] v_sync_w_i,
  input  logic [VW-1:0] v_back_i,
  input  logic [VW-1:0] v_act_i,
  input  logic [VW-1:0] v_total_i,
  input  logic [HW-1:0] hs_pos_i,
  input  logic          hs_porch_en_i,
  input  logic          hs_idle_i,
  input  logic          vs_idle_i,
  input  logic          de_idle_i,
  input  logic [DW-1:0] hs_dly_i,
  input  logic [DW-1:0] vs_dly_i,
  input  logic [DW-1:0] de_dly_i,
  input  logic          irq_en_i,
  input  logic          irq_clr_i,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          de_o,
  output logic          pix_req_o,
  output logic          frame_end_o,
  output logic          irq_status_o,
  output logic          irq_o,
  output logic [HW-1:0] h_cnt_o,
  output logic [VW-1:0] v_cnt_o
);
  logic          run, evt;
  logic [HW-1:0] h_cnt;
  logic [VW-1:0] v_cnt;
  sync_t         raw;
  logic [NSIG-1:0] raw_v, idle_v, act_v;
  logic [DW-1:0]   dly_v [NSIG];
  logic          pr_q, fe_q, st_q;

  rgb_sync_counter #(.HW(HW), .VW(VW)) u_cnt (
    .clk_i, .rst_ni, .pix_en_i, .start_i, .auto_next_i,
    .h_total_i, .v_total_i,
    .h_cnt_o(h_cnt), .v_cnt_o(v_cnt), .run_o(run), .frame_evt_o(evt)
  );

  rgb_sync_decode #(.HW(HW), .VW(VW)) u_dec (
    .run_i(run), .h_cnt_i(h_cnt), .v_cnt_i(v_cnt),
    .h_sync_w_i, .h_back_i, .h_act_i,
    .v_sync_w_i, .v_back_i, .v_act_i,
    .hs_pos_i, .hs_porch_en_i, .raw_o(raw)
  );

  assign raw_v    = {raw.de, raw.vs, raw.hs};
  assign idle_v   = {de_idle_i, vs_idle_i, hs_idle_i};
  assign dly_v[0] = hs_dly_i;
  assign dly_v[1] = vs_dly_i;
  assign dly_v[2] = de_dly_i;

  for (genvar s = 0; s < NSIG; s++) begin : g_sig
    rgb_sync_delay #(.DW(DW)) u_dly (
      .clk_i, .rst_ni, .d_i(raw_v[s]), .dly_i(dly_v[s]), .q_o(act_v[s])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pr_q <= 1'b0;
      fe_q <= 1'b0;
      st_q <= 1'b0;
    end else begin
      pr_q <= raw.de;
      fe_q <= evt;
      st_q <= evt | (st_q & ~irq_clr_i);
    end
  end

  assign hsync_o      = idle_v[0] ^ act_v[0];
  assign vsync_o      = idle_v[1] ^ act_v[1];
  assign de_o         = idle_v[2] ^ act_v[2];
  assign pix_req_o    = pr_q;
  assign frame_end_o  = fe_q;
  assign irq_status_o = st_q;
  assign irq_o        = st_q & irq_en_i;
  assign h_cnt_o      = h_cnt;
  assign v_cnt_o      = v_cnt;

  // R11
  status_follows_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end_o |-> irq_status_o);

  // R11
  status_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_clr_i && !evt) |=> !irq_status_o);

  // R10
  end_pulse_origin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(frame_end_o) |-> (h_cnt_o == '0 && v_cnt_o == '0));
endmodule

// File: tb/rgb_sync_gen_test.sv
`timescale 1ns/1ps
module rgb_sync_gen_test;
  localparam int HW = 12, VW = 11, DW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pix_en = 1'b0, start = 1'b0, auto_nx = 1'b1;
  logic [HW-1:0] hsw = 1, hbk = 3, hact = 3, htot = 9, hpos = 0;
  logic [VW-1:0] vsw = 0, vbk = 1, vact = 2, vtot = 5;
  logic porch = 1'b1, hid = 1'b0, vid = 1'b0, did = 1'b0;
  logic [DW-1:0] hd = 0, vd = 0, dd = 0;
  logic irq_en = 1'b1, irq_clr = 1'b0;
  logic hs_o, vs_o, de_o, pr_o, fe_o, st_o, irq_o;
  logic [HW-1:0] hc_o;
  logic [VW-1:0] vc_o;

  int n_cmp = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  rgb_sync_gen #(.HW(HW), .VW(VW), .DW(DW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .pix_en_i(pix_en), .start_i(start),
    .auto_next_i(auto_nx),
    .h_sync_w_i(hsw), .h_back_i(hbk), .h_act_i(hact), .h_total_i(htot),
    .v_sync_w_i(vsw), .v_back_i(vbk), .v_act_i(vact), .v_total_i(vtot),
    .hs_pos_i(hpos), .hs_porch_en_i(porch),
    .hs_idle_i(hid), .vs_idle_i(vid), .de_idle_i(did),
    .hs_dly_i(hd), .vs_dly_i(vd), .de_dly_i(dd),
    .irq_en_i(irq_en), .irq_clr_i(irq_clr),
    .hsync_o(hs_o), .vsync_o(vs_o), .de_o(de_o), .pix_req_o(pr_o),
    .frame_end_o(fe_o), .irq_status_o(st_o), .irq_o(irq_o),
    .h_cnt_o(hc_o), .v_cnt_o(vc_o)
  );

  // behavioural reference
  int m_h, m_v;
  bit m_run, m_fe, m_st, m_pr;
  bit hs_hist[4], vs_hist[4], de_hist[4];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_h = 0; m_v = 0; m_run = 0; m_fe = 0; m_st = 0; m_pr = 0;
      for (int k = 0; k < 4; k++) begin hs_hist[k] = 0; vs_hist[k] = 0; de_hist[k] = 0; end
    end else begin
      bit act_line, r_hs, r_vs, r_de, ev;
      act_line = (m_v >= int'(vbk) + 1) && (m_v <= int'(vbk) + 1 + int'(vact));
      r_hs = m_run && m_h >= int'(hpos) && m_h <= int'(hpos) + int'(hsw) && (act_line || porch);
      r_vs = m_run && m_v <= int'(vsw);
      r_de = m_run && act_line && m_h >= int'(hbk) + 1 && m_h <= int'(hbk) + 1 + int'(hact);
      for (int k = 3; k > 0; k--) begin
        hs_hist[k] = hs_hist[k-1]; vs_hist[k] = vs_hist[k-1]; de_hist[k] = de_hist[k-1];
      end
      hs_hist[0] = r_hs; vs_hist[0] = r_vs; de_hist[0] = r_de;
      m_pr = r_de;
      ev = m_run && pix_en && m_h == int'(htot) && m_v == int'(vtot);
      m_fe = ev;
      m_st = ev || (m_st && !irq_clr);
      if (start) begin
        m_run = 1; m_h = 0; m_v = 0;
      end else if (m_run && pix_en) begin
        if (m_h == int'(htot)) begin
          m_h = 0;
          if (m_v == int'(vtot)) begin
            m_v = 0;
            if (!auto_nx) m_run = 0;
          end else m_v++;
        end else m_h++;
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s t=%0t actual=%0d expected=%0d", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    chk("R2 h_cnt", int'(hc_o), m_h);
    chk("R2 v_cnt", int'(vc_o), m_v);
    chk("R3/R4/R7/R8 hsync", int'(hs_o), int'(hid ^ hs_hist[hd]));
    chk("R5/R7/R8 vsync", int'(vs_o), int'(vid ^ vs_hist[vd]));
    chk("R6/R7/R8 de", int'(de_o), int'(did ^ de_hist[dd]));
    chk("R6 pix_req", int'(pr_o), int'(m_pr));
    chk("R9/R10 frame_end", int'(fe_o), int'(m_fe));
    chk("R11 status", int'(st_o), int'(m_st));
    chk("R11 irq", int'(irq_o), int'(m_st && irq_en));
  end

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic step(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic pulse_start();
    start = 1'b1; step(1); start = 1'b0;
  endtask

  initial begin
    step(2);
    #1;
    // R1 during reset
    chk("R1 hsync idle", int'(hs_o), 0);
    chk("R1 h_cnt", int'(hc_o), 0);
    rst_n = 1'b1;
    step(3);
    chk("R1 frame_end", int'(fe_o), 0);
    chk("R1 irq", int'(irq_o), 0);

    // A: continuous, porch hsync, no delays, steady pixel enable
    pix_en = 1'b1;
    pulse_start();
    step(200);

    // B: single frame, active-low, truncated-free offset, delays, gappy enable
    auto_nx = 1'b0; porch = 1'b0; hid = 1'b1; vid = 1'b1; did = 1'b1;
    hd = 1; vd = 2; dd = 3; hpos = 5; irq_en = 1'b0;
    irq_clr = 1'b1; step(1); irq_clr = 1'b0;
    pulse_start();
    for (int c = 0; c < 300; c++) begin
      pix_en = (c % 3 != 0);
      step(1);
    end
    // R9 stopped after one frame
    chk("R9 stopped h_cnt", int'(hc_o), 0);
    chk("R9 stopped hsync idle", int'(hs_o), 1);
    chk("R7 stopped de idle", int'(de_o), 1);

    // C: pulse cut at line end, restart, clear and mask handling
    auto_nx = 1'b1; hpos = 8; hsw = 3; hid = 1'b0; did = 1'b0;
    hd = 3; vd = 0; dd = 1; irq_en = 1'b1; pix_en = 1'b0;
    pulse_start();   // start while enable low
    step(4);
    pix_en = 1'b1;
    step(25);
    pulse_start();   // R12 restart mid frame
    for (int c = 0; c < 400; c++) begin
      irq_clr = (c % 50 == 49);
      irq_en  = (c % 97 < 60);
      pix_en  = (c % 7 != 3);
      step(1);
    end
    irq_clr = 1'b0;
    // R12 second restart and collision of clear with frame end region
    pulse_start();
    step(120);
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog R1 actual=running expected=finished");
    summary();
  end
endmodule